// File: doc/BRIEF.md
# Hundredths-resolution stopwatch

The block is a free-standing stopwatch. A prescaler divides the system clock down to a 10 ms advance pulse. Each pulse steps a chain of three BCD digit pairs: hundredths (modulo 100), seconds (modulo 60) and minutes (modulo 60 by default). The six digits are decoded into active-high seven-segment patterns. Three active-low pushbuttons control the count: one starts it, one stops it and one clears it.

Each button line passes through a two-flop synchronizer. A command is raised only on a falling edge of the synchronized level, so a button held down gives exactly one command. The prescaler keeps its phase while the stopwatch is stopped, so a stop followed by a start loses no partial interval. The clear command zeroes the digits and the prescaler and leaves the stopwatch stopped.

Top module: `centi_stopwatch`

## Requirements
- R1: While `rstN` is low, and after it rises until a start command arrives, every display shows the zero glyph 0111111 (bit 0 = segment a) and no digit changes.
- R2: A button is active low on `btnN` (bit 0 start, bit 1 stop, bit 2 clear). The synchronized level is passed through two flops. A line that goes low just before clock edge 1 takes effect at rising edge 3. A line held low gives one command only, and a rising edge (release) gives none.
- R3: While running, the hundredths value advances by one every `TICK_DIV` running cycles. The first advance comes `TICK_DIV` edges after the start command's edge. Cycles spent stopped neither advance the digits nor move the prescaler phase.
- R4: A stop command freezes all digits. When start and stop commands arrive in the same cycle, stop wins.
- R5: A clear command zeroes all six digits and the prescaler and leaves the stopwatch stopped. It wins over start and stop in the same cycle.
- R6: Hundredths count 00 to 99. The advance that would pass 99 shows 00 and adds one second.
- R7: Seconds count 00 to 59. The advance from 59 shows 00 and adds one minute.
- R8: Minutes count 00 to `MIN_WRAP`-1. The advance from `MIN_WRAP`-1:59.99 returns every digit to 0.
- R9: `hex0`/`hex1` carry the hundredths ones/tens, `hex2`/`hex3` the seconds and `hex4`/`hex5` the minutes. The outputs are active high with bit 0 = segment a through bit 6 = segment g. The glyphs for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).
- R10: A start command while running, and a stop command while stopped, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnN | input | 3 | Active-low buttons: bit 0 start, bit 1 stop, bit 2 clear |
| hex0 | output | 7 | Hundredths ones glyph |
| hex1 | output | 7 | Hundredths tens glyph |
| hex2 | output | 7 | Seconds ones glyph |
| hex3 | output | 7 | Seconds tens glyph |
| hex4 | output | 7 | Minutes ones glyph |
| hex5 | output | 7 | Minutes tens glyph |

## Verification
The bench builds the block with `TICK_DIV` = 3 and `MIN_WRAP` = 2. With these values the full wrap back to 00:00.00 takes 12,000 advances, about 36,000 cycles, instead of hours of simulated time. A divider of 3 keeps the prescaler phase visible across stop and start, so a phase that is dropped or reset by mistake shows up as a wrong digit. The hundredths-to-seconds and seconds-to-minutes carries are checked directly before and after they happen.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef struct packed {
    logic clear;
    logic advance;
  } swStrobe_t;

  localparam int BTN_START = 0;
  localparam int BTN_STOP  = 1;
  localparam int BTN_CLEAR = 2;

  // active-high glyph, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [6:0] segGlyph(input logic [3:0] digit);
    case (digit)
      4'd0: segGlyph = 7'b0111111;
      4'd1: segGlyph = 7'b0000110;
      4'd2: segGlyph = 7'b1011011;
      4'd3: segGlyph = 7'b1001111;
      4'd4: segGlyph = 7'b1100110;
      4'd5: segGlyph = 7'b1101101;
      4'd6: segGlyph = 7'b1111101;
      4'd7: segGlyph = 7'b0000111;
      4'd8: segGlyph = 7'b1111111;
      4'd9: segGlyph = 7'b1101111;
      default: segGlyph = 7'b0000000;
    endcase
  endfunction

endpackage

// File: rtl/bcd_pair.sv
module bcd_pair #(
  parameter int WRAP = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clear,
  input  logic       inc,
  output logic       carry,
  output logic [3:0] ones,
  output logic [3:0] tens
);
  localparam logic [3:0] LAST_ONES = 4'((WRAP - 1) % 10);
  localparam logic [3:0] LAST_TENS = 4'((WRAP - 1) / 10);

  logic atLast;
  assign atLast = (ones == LAST_ONES) && (tens == LAST_TENS);
  assign carry  = inc && atLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ones <= '0;
      tens <= '0;
    end else if (clear) begin
      ones <= '0;
      tens <= '0;
    end else if (inc) begin
      if (atLast) begin
        ones <= '0;
        tens <= '0;
      end else if (ones == 4'd9) begin
        ones <= '0;
        tens <= tens + 4'd1;
      end else begin
        ones <= ones + 4'd1;
      end
    end
  end
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
#(
  parameter int TICK_DIV    = 2_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] btnN,
  output swStrobe_t  strobe,
  output logic       running,
  output logic [2:0] cmdPulse
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic [2:0]       syncStage [SYNC_STAGES];
  logic [2:0]       prevLvl;
  logic [2:0]       syncLvl;
  logic [CNT_W-1:0] phase;

  assign syncLvl  = syncStage[SYNC_STAGES-1];
  assign cmdPulse = prevLvl & ~syncLvl;

  assign strobe.clear   = cmdPulse[BTN_CLEAR];
  assign strobe.advance = running && (phase == CNT_LAST) && !cmdPulse[BTN_CLEAR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '1;
      prevLvl <= '1;
      running <= 1'b0;
      phase   <= '0;
    end else begin
      syncStage[0] <= btnN;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
      prevLvl <= syncLvl;
      if (cmdPulse[BTN_CLEAR]) begin
        running <= 1'b0;
        phase   <= '0;
      end else begin
        if (cmdPulse[BTN_STOP])       running <= 1'b0;
        else if (cmdPulse[BTN_START]) running <= 1'b1;
        if (running) phase <= (phase == CNT_LAST) ? '0 : phase + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sw_datapath.sv
module sw_datapath
  import sw_pkg::*;
#(
  parameter int MIN_WRAP = 60
) (
  input  logic            clk,
  input  logic            rstN,
  input  swStrobe_t       strobe,
  output logic [5:0][3:0] digits,
  output logic            fullWrap
);
  localparam int PAIRS = 3;

  function automatic int wrapOf(input int idx);
    wrapOf = (idx == 0) ? 100 : (idx == 1) ? 60 : MIN_WRAP;
  endfunction

  logic [PAIRS-1:0] carry;

  for (genvar g = 0; g < PAIRS; g++) begin : gPair
    logic pairInc;
    if (g == 0) begin : gFirst
      assign pairInc = strobe.advance;
    end else begin : gRest
      assign pairInc = carry[g-1];
    end
    bcd_pair #(.WRAP(wrapOf(g))) uPair (
      .clk   (clk),
      .rstN  (rstN),
      .clear (strobe.clear),
      .inc   (pairInc),
      .carry (carry[g]),
      .ones  (digits[2*g]),
      .tens  (digits[2*g+1])
    );
  end

  assign fullWrap = carry[PAIRS-1];
endmodule

// File: rtl/centi_stopwatch.sv
module centi_stopwatch
  import sw_pkg::*;
#(
  parameter int TICK_DIV    = 2_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WRAP    = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] btnN,
  output logic [6:0] hex0,
  output logic [6:0] hex1,
  output logic [6:0] hex2,
  output logic [6:0] hex3,
  output logic [6:0] hex4,
  output logic [6:0] hex5
);
  swStrobe_t       strobe;
  logic            running;
  logic [2:0]      cmdPulse;
  logic [5:0][3:0] digits;
  logic            fullWrap;
  logic [5:0][6:0] segs;

  sw_ctrl #(.TICK_DIV(TICK_DIV), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .btnN(btnN),
    .strobe(strobe), .running(running), .cmdPulse(cmdPulse)
  );

  sw_datapath #(.MIN_WRAP(MIN_WRAP)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .digits(digits), .fullWrap(fullWrap)
  );

  for (genvar g = 0; g < 6; g++) begin : gSeg
    assign segs[g] = segGlyph(digits[g]);
  end

  assign hex0 = segs[0];
  assign hex1 = segs[1];
  assign hex2 = segs[2];
  assign hex3 = segs[3];
  assign hex4 = segs[4];
  assign hex5 = segs[5];
endmodule

// File: rtl/sw_checker.sv
module sw_checker
  import sw_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input swStrobe_t       strobe,
  input logic            running,
  input logic [2:0]      cmdPulse,
  input logic [5:0][3:0] digits,
  input logic            fullWrap
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPulse != 3'b000) |=> ((cmdPulse & $past(cmdPulse)) == 3'b000));

  a_r3_advance_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> running);

  a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobe.clear) |=> $stable(digits));

  a_r4_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    cmdPulse[BTN_STOP] |=> !running);

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    cmdPulse[BTN_CLEAR] |=> (digits == '0 && !running));

  a_r6_hund_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && digits[1] == 4'd9 && digits[0] == 4'd9) |=>
      (digits[1] == 4'd0 && digits[0] == 4'd0));

  a_r7_digit_range: assert property (@(posedge clk) disable iff (!rstN)
    (digits[0] <= 4'd9 && digits[1] <= 4'd9 && digits[2] <= 4'd9 &&
     digits[3] <= 4'd5 && digits[4] <= 4'd9));

  a_r8_full_wrap: assert property (@(posedge clk) disable iff (!rstN)
    fullWrap |=> (digits == '0));
endmodule

bind centi_stopwatch sw_checker uChk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .running(running),
  .cmdPulse(cmdPulse), .digits(digits), .fullWrap(fullWrap)
);

// File: tb/sim_centi_stopwatch.sv
`timescale 1ns/1ps
module sim_centi_stopwatch;
  localparam int DIV  = 3;
  localparam int MINW = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] btnN = 3'b111;
  logic [6:0] hex0, hex1, hex2, hex3, hex4, hex5;

  int  runCycles = 0;
  bit  mRun = 0;
  int  nChecks = 0;
  int  nFails = 0;

  always #4 clk = ~clk;

  centi_stopwatch #(.TICK_DIV(DIV), .SYNC_STAGES(2), .MIN_WRAP(MINW)) u0 (
    .clk(clk), .rstN(rstN), .btnN(btnN),
    .hex0(hex0), .hex1(hex1), .hex2(hex2), .hex3(hex3), .hex4(hex4), .hex5(hex5)
  );

  function automatic logic [6:0] glyph(input int d);
    case (d)
      0: glyph = 7'h3F; 1: glyph = 7'h06; 2: glyph = 7'h5B; 3: glyph = 7'h4F;
      4: glyph = 7'h66; 5: glyph = 7'h6D; 6: glyph = 7'h7D; 7: glyph = 7'h07;
      8: glyph = 7'h7F; default: glyph = 7'h6F;
    endcase
  endfunction

  function automatic logic [41:0] expectHex(input int cycles);
    int t, h, s, m;
    t = (cycles / DIV) % (100 * 60 * MINW);
    h = t % 100;
    s = (t / 100) % 60;
    m = t / 6000;
    expectHex = {glyph(m / 10), glyph(m % 10), glyph(s / 10), glyph(s % 10),
                 glyph(h / 10), glyph(h % 10)};
  endfunction

  // one rising edge; cmd is the command the requirements place at this edge
  task automatic cycle(input logic [2:0] cmd);
    @(posedge clk);
    if (cmd[2]) begin
      runCycles = 0;
      mRun = 0;
    end else begin
      if (mRun) runCycles++;
      if (cmd[1]) mRun = 0;
      else if (cmd[0]) mRun = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(3'b000);
  endtask

  task automatic press(input logic [2:0] mask);
    btnN = btnN & ~mask;
    cycle(3'b000);
    cycle(3'b000);
    cycle(mask);
    btnN = btnN | mask;
    idle(3);
  endtask

  task automatic check(input string tag);
    logic [41:0] act, exp;
    act = {hex5, hex4, hex3, hex2, hex1, hex0};
    exp = expectHex(runCycles);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: hex=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic runUntil(input int ticks);
    while (runCycles / DIV < ticks) cycle(3'b000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20211));
    repeat (3) @(negedge clk);
    check("R1 zero glyphs during reset");
    rstN = 1'b1;
    idle(30);
    check("R1 stays zero after reset");

    // R2: latency of the start command, then first advance per R3
    btnN[0] = 1'b0;
    cycle(3'b000);
    cycle(3'b000);
    check("R2 no effect before third edge");
    cycle(3'b001);
    for (int i = 0; i < 40; i++) cycle(3'b000);   // start held low
    check("R3 counting with start held");
    press(3'b010);
    idle(25);
    check("R2 held start gives one command");
    btnN[0] = 1'b1;
    idle(10);
    check("R2 release gives no command");

    // R4: start and stop together while stopped
    press(3'b011);
    idle(20);
    check("R4 stop wins over start");
    press(3'b010);
    idle(10);
    check("R10 stop while stopped");
    press(3'b001);
    idle(17);
    press(3'b001);
    idle(20);
    check("R10 start while running");
    press(3'b011);
    idle(10);
    check("R4 stop wins while running");

    // R5: clear beats start and stop
    press(3'b001);
    idle(50);
    press(3'b111);
    idle(20);
    check("R5 clear over start and stop");

    // carries
    press(3'b001);
    runUntil(99);
    check("R6 hundredths at 99");
    runUntil(100);
    check("R6 hundredths carry to seconds");
    runUntil(5999);
    check("R7 seconds at 59.99");
    runUntil(6000);
    check("R7 seconds carry to minutes");
    runUntil(6000 * MINW - 1);
    check("R8 last value before wrap");
    runUntil(6000 * MINW);
    check("R8 full wrap to zero");
    runUntil(6000 * MINW + 457);
    check("R9 glyphs of mid-range digits");

    // random commands
    for (int i = 0; i < 60; i++) begin
      int r;
      r = $urandom % 16;
      if (r < 6)       press(3'b001);
      else if (r < 11) press(3'b010);
      else if (r < 14) press(3'b011);
      else if (r < 15) press(3'b100);
      idle($urandom_range(1, 300));
      check("R3 R9 random commands");
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule